// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel running in waveform mode. A single up-counter, clocked through a selectable prescaler, counts from zero to the period value and then wraps. Two outputs, A and B, share that counter and that period. Each output has its own duty compare value. Each output also has its own set, clear or toggle action for three events: its duty compare, the period compare, and a software trigger.

Software programs the channel through a write-only register port. It loads the mode word, the two duty values and the period value, and then issues a command word. The command word can start the count clock, stop it, and fire the software trigger. The trigger restarts the count and drives each output to a programmed starting level. With normal polarity, an output is set at the period compare and cleared at its duty compare. Inverting the polarity swaps those two actions. When both compare actions are left at "none", the output holds whatever level the last trigger gave it, which gives a steady 0% or 100% output.

Top module: `dwt_channel`

## Requirements
- R1: After reset the counter is 0, both outputs are low, the clock is stopped, all action fields are none (00), and the count does not move until the clock is started.
- R2: Mode bits [2:0] select the count rate. Codes 0, 1, 2 and 3 give one count tick every 2, 8, 32 and 128 clock cycles. The first tick comes that many cycles after the clock is started or the trigger fires.
- R3: Mode codes 4 to 7 in bits [2:0] make the counter advance once in every cycle in which the `slow_tick` input is high, and never on the prescaler.
- R4: On each tick the counter adds one, except when it equals the period register. In that case it returns to 0, so one period lasts (period+1) ticks. The count is visible on `count`.
- R5: Each action field is 2 bits: 00 none, 01 set, 10 clear, 11 toggle. Mode bits [4:3], [6:5] and [8:7] hold output A's actions for the duty-A compare, the period compare and the trigger. Bits [10:9], [12:11] and [14:13] hold the same three actions for output B, with B's compare against duty-B. A compare fires on a tick where the counter value before the update equals the register.
- R6: When events meet in one cycle, the trigger action wins over the period action, and a period action other than none wins over the duty action.
- R7: A software trigger zeroes the counter and the prescaler and applies each output's trigger action at that clock edge. This happens whether the clock is running or stopped.
- R8: Command bits are: bit 0 starts the clock, bit 1 stops it, and bit 2 fires the trigger. Stop wins over start. Stop together with trigger applies the trigger levels and leaves the count frozen at 0.
- R9: An output whose compare actions are both none keeps its last trigger level while the counter runs.
- R10: Write addresses are 0 mode, 1 duty A, 2 duty B, 3 period and 4 command. A write takes effect at the clock edge that samples it. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable pulses from the slow time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CNT_W | Current counter value |

## Verification
The hardest case to reach from the ports is a software trigger landing in the same clock edge as a period compare. That needs a prescaler tick and a counter value equal to the period at the moment the command write is sampled. The bench sets the fastest rate and a period of 0, so every tick is a period compare. It then issues the trigger write exactly two cycles after starting the clock, which lands it on the first tick. The sweep also sets the duty value equal to the period to hit the period-over-duty ordering. Each waveform is compared cycle by cycle with a closed-form value: output A is high when the count is at most its duty value.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // Field order sets bit positions: clk_sel in [2:0], b_trg in [14:13]
  typedef struct packed {
    act_e       b_trg;
    act_e       b_per;
    act_e       b_cmp;
    act_e       a_trg;
    act_e       a_per;
    act_e       a_cmp;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W  = $bits(mode_t);
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 3;
  localparam int N_DIV   = 4;

  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DA   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DB   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd4;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/dwt_prescale.sv
module dwt_prescale
  import dwt_pkg::*;
#(
  parameter int N_SEL_DIV = N_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);
  localparam int PRE_W = 2 * N_SEL_DIV - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;
  logic             slow;

  // divisor is 2 << (2*sel); the limit is the divisor minus one
  always_comb begin
    lim = '1;
    lim = lim >> (2 * (N_SEL_DIV - 1) - 2 * int'(sel[1:0]));
  end

  assign slow = sel[SEL_W-1];
  assign tick = run && (slow ? slow_tick : (pre == lim));

  always_ff @(posedge clk) begin
    if (rst || restart || !run || slow) begin
      pre <= '0;
    end else if (pre == lim) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

endmodule

// File: rtl/dwt_count.sv
module dwt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == period) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dwt_act.sv
module dwt_act
  import dwt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  act_e trg_act,
  input  logic per_hit,
  input  act_e per_act,
  input  logic cmp_hit,
  input  act_e cmp_act,
  output logic lvl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0;
    end else if (trig) begin
      lvl <= apply_act(trg_act, lvl);
    end else if (per_hit && per_act != ACT_NONE) begin
      lvl <= apply_act(per_act, lvl);
    end else if (cmp_hit) begin
      lvl <= apply_act(cmp_act, lvl);
    end
  end

endmodule

// File: rtl/dwt_channel.sv
module dwt_channel
  import dwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              out_a,
  output logic              out_b,
  output logic [CNT_W-1:0]  count
);
  localparam int N_OUT = 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] duty_q [N_OUT];
  logic [CNT_W-1:0] rc_q;
  logic             clk_on;
  logic             cmd_wr;
  logic             trig;
  logic             tick;
  logic             per_hit;
  logic [CNT_W-1:0] cnt;

  assign cmd_wr = wr_en && (wr_addr == ADR_CMD);
  assign trig   = cmd_wr && wr_data[CMD_TRIG];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      duty_q[0] <= '0;
      duty_q[1] <= '0;
      rc_q      <= '0;
      clk_on    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_MODE: mode_q    <= mode_t'(wr_data[MODE_W-1:0]);
        ADR_DA:   duty_q[0] <= wr_data;
        ADR_DB:   duty_q[1] <= wr_data;
        ADR_PER:  rc_q      <= wr_data;
        ADR_CMD: begin
          if (wr_data[CMD_STOP]) clk_on <= 1'b0;
          else if (wr_data[CMD_START]) clk_on <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  dwt_prescale u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (clk_on),
    .restart  (trig),
    .sel      (mode_q.clk_sel),
    .slow_tick(slow_tick),
    .tick     (tick)
  );

  dwt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .restart(trig),
    .tick   (tick),
    .period (rc_q),
    .cnt    (cnt)
  );

  assign per_hit = tick && (cnt == rc_q);

  act_e             cmp_act [N_OUT];
  act_e             per_act [N_OUT];
  act_e             trg_act [N_OUT];
  logic [N_OUT-1:0] lvl;

  always_comb begin
    cmp_act[0] = mode_q.a_cmp;
    per_act[0] = mode_q.a_per;
    trg_act[0] = mode_q.a_trg;
    cmp_act[1] = mode_q.b_cmp;
    per_act[1] = mode_q.b_per;
    trg_act[1] = mode_q.b_trg;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    dwt_act u_act (
      .clk    (clk),
      .rst    (rst),
      .trig   (trig),
      .trg_act(trg_act[g]),
      .per_hit(per_hit),
      .per_act(per_act[g]),
      .cmp_hit(tick && (cnt == duty_q[g])),
      .cmp_act(cmp_act[g]),
      .lvl    (lvl[g])
    );
  end

  assign out_a = lvl[0];
  assign out_b = lvl[1];
  assign count = cnt;

endmodule

// File: rtl/dwt_channel_chk.sv
module dwt_channel_chk
  import dwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [2:0]        cmd_bits,
  input logic              out_a,
  input logic              out_b,
  input logic [CNT_W-1:0]  count,
  input logic              tick,
  input logic [CNT_W-1:0]  rc_q,
  input act_e              a_trg,
  input act_e              b_trg
);
  logic trig_w, stop_w;
  assign trig_w = wr_en && (wr_addr == 3'd4) && cmd_bits[2];
  assign stop_w = wr_en && (wr_addr == 3'd4) && cmd_bits[1];

  assert_trig_zero_R7: assert property (@(posedge clk) disable iff (rst)
    trig_w |=> (count == '0));

  assert_trig_set_a_R7: assert property (@(posedge clk) disable iff (rst)
    (trig_w && a_trg == ACT_SET) |=> out_a);

  assert_trig_clr_b_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_w && b_trg == ACT_CLR) |=> !out_b);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !trig_w) |=> ($stable(out_a) && $stable(out_b)));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !trig_w) |=> $stable(count));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !trig_w && count == rc_q) |=> (count == '0));

  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> !tick);

endmodule

bind dwt_channel dwt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .cmd_bits(wr_data[2:0]),
  .out_a   (out_a),
  .out_b   (out_b),
  .count   (count),
  .tick    (tick),
  .rc_q    (rc_q),
  .a_trg   (mode_q.a_trg),
  .b_trg   (mode_q.b_trg)
);

// File: tb/sim_dwt_channel.sv
module sim_dwt_channel;
  import dwt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         slow_tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         out_a, out_b;
  logic [W-1:0] count;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dwt_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_a(out_a), .out_b(out_b),
    .count(count)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(int addr, int data);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int mk_mode(int sel, act_e acmp, act_e aper, act_e atrg,
                                 act_e bcmp, act_e bper, act_e btrg);
    return {16'd0, 1'b0, btrg, bper, bcmp, atrg, aper, acmp, 3'(sel)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count after reset", 32'(count), 0);
    chk("R1 out_a after reset", 32'(out_a), 0);
    chk("R1 out_b after reset", 32'(out_b), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 count idle", 32'(count), 0);

    // R10: writes to unused addresses with a start+trigger pattern do nothing
    wr(3, 2);
    for (int a = 5; a < 8; a++) wr(a, 7);
    repeat (8) @(negedge clk);
    chk("R10 unused addr count", 32'(count), 0);
    chk("R10 unused addr out_a", 32'(out_a), 0);

    // sweep: A normal polarity, B inverted polarity
    for (int sel = 0; sel < 4; sel++) begin
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < 4; k++) begin
          int rc, ra, rb, dv, nmax;
          rc = (r == 0) ? 3 : 5;
          case (k)
            0: begin ra = 0;      rb = 1;      end
            1: begin ra = 2;      rb = rc;     end
            2: begin ra = rc;     rb = 0;      end
            default: begin ra = rc + 2; rb = rc + 1; end
          endcase
          dv = 2 << (2 * sel);
          nmax = dv * (rc + 1) * 2 + 3;
          wr(4, 2);
          wr(0, mk_mode(sel, ACT_CLR, ACT_SET, ACT_SET, ACT_SET, ACT_CLR, ACT_CLR));
          wr(1, ra);
          wr(2, rb);
          wr(3, rc);
          wr(4, 5);
          for (int n = 0; n <= nmax; n++) begin
            int t, c;
            if (n > 0) @(negedge clk);
            t = n / dv;
            c = t % (rc + 1);
            chk("R2/R4 count", 32'(count), 32'(c));
            chk((ra == rc) ? "R6 out_a period over duty" : "R5 out_a",
                32'(out_a), (c <= ra) ? 1 : 0);
            chk((rb == rc) ? "R6 out_b period over duty" : "R5 out_b",
                32'(out_b), (c <= rb) ? 0 : 1);
          end
        end
      end
    end

    // R3 slow time base, R9 constant outputs with no compare actions
    wr(4, 2);
    wr(0, mk_mode(4, ACT_NONE, ACT_NONE, ACT_CLR, ACT_NONE, ACT_NONE, ACT_CLR));
    wr(3, 4);
    wr(4, 5);
    begin
      int np;
      np = 0;
      for (int i = 0; i < 40; i++) begin
        chk("R3 slow count", 32'(count), 32'(np % 5));
        chk("R9 out_a constant low", 32'(out_a), 0);
        slow_tick = (i % 3 == 2);
        if (slow_tick) np++;
        @(negedge clk);
      end
      slow_tick = 1'b0;
    end

    wr(0, mk_mode(0, ACT_NONE, ACT_NONE, ACT_SET, ACT_NONE, ACT_NONE, ACT_CLR));
    wr(3, 3);
    wr(4, 5);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9 out_a constant high", 32'(out_a), 1);
    end

    // R8 stop+trigger, R7 trigger while stopped, R5 toggle action
    wr(0, mk_mode(0, ACT_NONE, ACT_NONE, ACT_SET, ACT_NONE, ACT_NONE, ACT_TGL));
    wr(4, 6);
    chk("R8 stop+trigger count", 32'(count), 0);
    chk("R8 stop+trigger out_a", 32'(out_a), 1);
    chk("R5 toggle out_b", 32'(out_b), 1);
    repeat (20) @(negedge clk);
    chk("R8 frozen count", 32'(count), 0);
    wr(4, 4);
    chk("R7 trigger while stopped count", 32'(count), 0);
    chk("R5 toggle back out_b", 32'(out_b), 0);
    chk("R7 trigger while stopped out_a", 32'(out_a), 1);
    wr(4, 1);
    chk("R8 start no trigger n0", 32'(count), 0);
    @(negedge clk);
    chk("R8 start no trigger n1", 32'(count), 0);
    @(negedge clk);
    chk("R8 start no trigger n2", 32'(count), 1);
    wr(4, 3);
    begin
      logic [W-1:0] held;
      held = count;
      repeat (10) @(negedge clk);
      chk("R8 stop wins over start", 32'(count), 32'(held));
    end

    // R6 trigger coinciding with a period compare
    wr(4, 2);
    wr(0, mk_mode(0, ACT_NONE, ACT_CLR, ACT_SET, ACT_NONE, ACT_NONE, ACT_NONE));
    wr(1, 0);
    wr(3, 0);
    wr(4, 5);
    @(negedge clk);
    chk("R6 before first tick out_a", 32'(out_a), 1);
    wr(4, 4);
    chk("R6 trigger beats period clear", 32'(out_a), 1);
    @(negedge clk);
    chk("R6 restarted prescaler hold", 32'(out_a), 1);
    @(negedge clk);
    chk("R6 period clear after restart", 32'(out_a), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule